// File: doc/BRIEF.md
# Anti-Replay Configuration Update Controller

This block is the control engine that accepts an authenticated remote configuration update inside a programmable device. A request carries a command word and the tag computed over it. Once the command is accepted, a stream of encrypted configuration words follows, and the tag for that stream arrives with the final word. The controller drives an external keyed-MAC engine to compute reference tags. It compares each reference tag with the received tag over the full tag width. It advances a persistent version register by one only when both comparisons succeed.

Each MAC computation ends with a trailer. The trailer holds a 2-bit domain code and the candidate version, which is the stored version plus one. This binds every tag to one specific next version, so a recorded update cannot be replayed later. A command tag mismatch stops the sequence before any configuration data is taken. On full success the controller pulses a write-enable, which tells the external memory to store the data and its tag. Every outcome finishes with a one-cycle done pulse and a result code that is held until the next outcome.

Top module: `cfg_update_guard`

## Requirements
- R1: An accepted update request sends the command to the MAC engine as the first word, zero-extended and flagged with start. The trailer follows: {2'b00, stored version + 1}, zero-extended to whole words and sent most significant word first. Last is flagged on the final trailer word.
- R2: The configuration stream is forwarded only after the command tag matched. The data words go out in arrival order, with start on the first word. The trailer {2'b01, stored version + 1} follows in the same word layout as R1.
- R3: A command tag mismatch ends the update with result code 2 and raises integ_fail. No configuration word is accepted (dat_ready stays low), and no further MAC traffic occurs.
- R4: The version register changes only on full success, and then by exactly +1.
- R5: commit_we is a single-cycle pulse. It occurs only together with done and result code 1 (success).
- R6: A configuration tag mismatch ends the update with result code 3, raises integ_fail, and leaves the version unchanged.
- R7: Tag comparison covers every bit. A difference in only the most significant bit, or only the least significant bit, is a mismatch.
- R8: A request whose opcode (the top OPC_W bits of the command) is not UPDATE_OPC is ignored. It causes no MAC traffic, no done pulse, and no change of result or version.
- R9: done is a one-cycle pulse per outcome. result and integ_fail change only together with done and hold their values in between.
- R10: An update request while the version is all ones is refused at once with result code 4 and integ_fail low. There is no MAC traffic and the version does not wrap.
- R11: After reset, done, commit_we, integ_fail, dat_ready, mac_valid and mac_start are low, result is 0, and the version equals VER_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_cmd | input | CMD_W | Command word, opcode in the top OPC_W bits |
| req_tag | input | TAG_W | Tag received for the command |
| dat_valid | input | 1 | Configuration word valid |
| dat_ready | output | 1 | Controller accepts configuration words |
| dat_word | input | DATA_W | Encrypted configuration word |
| dat_last | input | 1 | Marks the final configuration word |
| dat_tag | input | TAG_W | Tag received for the stream, sampled with the final word |
| mac_start | output | 1 | First word of a MAC computation |
| mac_valid | output | 1 | MAC input word valid |
| mac_word | output | DATA_W | MAC input word |
| mac_last | output | 1 | Final word of a MAC computation |
| mac_done | input | 1 | MAC result valid |
| mac_result | input | TAG_W | Computed tag |
| ver_q | output | VER_W | Persistent version register |
| commit_we | output | 1 | Write-enable pulse to the external configuration store |
| done | output | 1 | Outcome pulse |
| result | output | 3 | 0 none, 1 success, 2 command tag bad, 3 data tag bad, 4 version exhausted |
| integ_fail | output | 1 | Set by the last outcome if it was a tag mismatch |

## Verification
The bench builds the block with an 8-bit version that starts at 8'hFD. Two successful commits therefore bring the all-ones version within reach, and the exhaustion refusal can be exercised directly. It uses 8-bit words, so the 10-bit trailer spans two MAC words, and the ordering of a multi-word trailer is checked word by word. Tags are 16 bits wide. This lets the bench flip only the top bit of a command tag or only the bottom bit of a data tag to probe the full-width compare.

// File: rtl/cug_pkg.sv
package cug_pkg;

    typedef enum logic [2:0] {
        RES_NONE      = 3'd0,
        RES_OK        = 3'd1,
        RES_CMD_BAD   = 3'd2,
        RES_DAT_BAD   = 3'd3,
        RES_EXHAUSTED = 3'd4
    } cug_res_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TRAILER,
        ST_WAIT,
        ST_CHECK,
        ST_DATA
    } cug_state_e;

    localparam logic [1:0] DOM_CMD = 2'b00;
    localparam logic [1:0] DOM_DAT = 2'b01;

    function automatic int unsigned cug_words(input int unsigned bits, input int unsigned width);
        return (bits + width - 1) / width;
    endfunction

endpackage

// File: rtl/cug_version.sv
module cug_version #(
    parameter int unsigned          VER_W    = 64,
    parameter logic [VER_W-1:0]     VER_INIT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    output logic [VER_W-1:0] ver_q,
    output logic [VER_W-1:0] ver_cand,
    output logic             at_max
);

    assign ver_cand = ver_q + 1'b1;
    assign at_max   = &ver_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ver_q <= VER_INIT;
        end else if (bump && !at_max) begin
            ver_q <= ver_cand;
        end
    end

endmodule

// File: rtl/cug_trailer.sv
module cug_trailer
    import cug_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned VER_W  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [1:0]        dom,
    input  logic [VER_W-1:0]  cand,
    input  logic              shift,
    output logic [DATA_W-1:0] word,
    output logic              is_last
);

    localparam int unsigned TRL_N    = cug_words(VER_W + 2, DATA_W);
    localparam int unsigned TRL_BITS = TRL_N * DATA_W;
    localparam int unsigned CNT_W    = $clog2(TRL_N + 1);

    logic [TRL_BITS-1:0] sr;
    logic [CNT_W-1:0]    cnt;

    assign word    = sr[TRL_BITS-1 -: DATA_W];
    assign is_last = (cnt == CNT_W'(1));

    generate
        if (TRL_N == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    sr  <= '0;
                    cnt <= '0;
                end else if (load) begin
                    sr              <= '0;
                    sr[VER_W+1:0]   <= {dom, cand};
                    cnt             <= CNT_W'(1);
                end else if (shift) begin
                    cnt <= '0;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) begin
                    sr  <= '0;
                    cnt <= '0;
                end else if (load) begin
                    sr              <= '0;
                    sr[VER_W+1:0]   <= {dom, cand};
                    cnt             <= CNT_W'(TRL_N);
                end else if (shift && cnt != '0) begin
                    sr  <= sr << DATA_W;
                    cnt <= cnt - 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cug_tag_cmp.sv
module cug_tag_cmp #(
    parameter int unsigned TAG_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample,
    input  logic [TAG_W-1:0] calc,
    input  logic [TAG_W-1:0] expect_tag,
    output logic             match_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= 1'b0;
        end else if (sample) begin
            match_q <= (calc == expect_tag);
        end
    end

endmodule

// File: rtl/cfg_update_guard.sv
module cfg_update_guard
    import cug_pkg::*;
#(
    parameter int unsigned          CMD_W      = 32,
    parameter int unsigned          DATA_W     = 32,
    parameter int unsigned          TAG_W      = 128,
    parameter int unsigned          VER_W      = 64,
    parameter logic [VER_W-1:0]     VER_INIT   = '0,
    parameter int unsigned          OPC_W      = 8,
    parameter logic [OPC_W-1:0]     UPDATE_OPC = 8'hC1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              dat_valid,
    output logic              dat_ready,
    input  logic [DATA_W-1:0] dat_word,
    input  logic              dat_last,
    input  logic [TAG_W-1:0]  dat_tag,
    output logic              mac_start,
    output logic              mac_valid,
    output logic [DATA_W-1:0] mac_word,
    output logic              mac_last,
    input  logic              mac_done,
    input  logic [TAG_W-1:0]  mac_result,
    output logic [VER_W-1:0]  ver_q,
    output logic              commit_we,
    output logic              done,
    output logic [2:0]        result,
    output logic              integ_fail
);

    cug_state_e       state;
    cug_res_e         res_q;
    logic             phase;
    logic             first;
    logic [TAG_W-1:0] cmd_tag_q;
    logic [TAG_W-1:0] dat_tag_q;

    logic              is_upd;
    logic              at_max;
    logic [VER_W-1:0]  ver_cand;
    logic              ver_bump;
    logic              trl_load;
    logic [1:0]        trl_dom;
    logic              trl_shift;
    logic [DATA_W-1:0] trl_word;
    logic              trl_last;
    logic              cmp_sample;
    logic [TAG_W-1:0]  cmp_expect;
    logic              match_q;

    assign is_upd     = (req_cmd[CMD_W-1 -: OPC_W] == UPDATE_OPC);
    assign dat_ready  = (state == ST_DATA);
    assign result     = res_q;

    assign trl_load   = ((state == ST_IDLE) && req_valid && is_upd && !at_max) ||
                        ((state == ST_DATA) && dat_valid && dat_last);
    assign trl_dom    = (state == ST_DATA) ? DOM_DAT : DOM_CMD;
    assign trl_shift  = (state == ST_TRAILER);
    assign cmp_sample = (state == ST_WAIT) && mac_done;
    assign cmp_expect = phase ? dat_tag_q : cmd_tag_q;
    assign ver_bump   = (state == ST_CHECK) && phase && match_q;

    cug_version #(
        .VER_W    (VER_W),
        .VER_INIT (VER_INIT)
    ) u_version (
        .clk      (clk),
        .rst      (rst),
        .bump     (ver_bump),
        .ver_q    (ver_q),
        .ver_cand (ver_cand),
        .at_max   (at_max)
    );

    cug_trailer #(
        .DATA_W (DATA_W),
        .VER_W  (VER_W)
    ) u_trailer (
        .clk     (clk),
        .rst     (rst),
        .load    (trl_load),
        .dom     (trl_dom),
        .cand    (ver_cand),
        .shift   (trl_shift),
        .word    (trl_word),
        .is_last (trl_last)
    );

    cug_tag_cmp #(
        .TAG_W (TAG_W)
    ) u_cmp (
        .clk        (clk),
        .rst        (rst),
        .sample     (cmp_sample),
        .calc       (mac_result),
        .expect_tag (cmp_expect),
        .match_q    (match_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            res_q      <= RES_NONE;
            phase      <= 1'b0;
            first      <= 1'b0;
            cmd_tag_q  <= '0;
            dat_tag_q  <= '0;
            mac_start  <= 1'b0;
            mac_valid  <= 1'b0;
            mac_last   <= 1'b0;
            mac_word   <= '0;
            done       <= 1'b0;
            commit_we  <= 1'b0;
            integ_fail <= 1'b0;
        end else begin
            mac_start <= 1'b0;
            mac_valid <= 1'b0;
            mac_last  <= 1'b0;
            done      <= 1'b0;
            commit_we <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid && is_upd) begin
                        if (at_max) begin
                            res_q      <= RES_EXHAUSTED;
                            integ_fail <= 1'b0;
                            done       <= 1'b1;
                        end else begin
                            cmd_tag_q              <= req_tag;
                            phase                  <= 1'b0;
                            mac_start              <= 1'b1;
                            mac_valid              <= 1'b1;
                            mac_word               <= '0;
                            mac_word[CMD_W-1:0]    <= req_cmd;
                            state                  <= ST_TRAILER;
                        end
                    end
                end
                ST_TRAILER: begin
                    mac_valid <= 1'b1;
                    mac_word  <= trl_word;
                    mac_last  <= trl_last;
                    if (trl_last) begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mac_done) begin
                        state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!match_q) begin
                        res_q      <= phase ? RES_DAT_BAD : RES_CMD_BAD;
                        integ_fail <= 1'b1;
                        done       <= 1'b1;
                        state      <= ST_IDLE;
                    end else if (!phase) begin
                        phase <= 1'b1;
                        first <= 1'b1;
                        state <= ST_DATA;
                    end else begin
                        res_q      <= RES_OK;
                        integ_fail <= 1'b0;
                        done       <= 1'b1;
                        commit_we  <= 1'b1;
                        state      <= ST_IDLE;
                    end
                end
                ST_DATA: begin
                    if (dat_valid) begin
                        mac_valid <= 1'b1;
                        mac_start <= first;
                        mac_word  <= dat_word;
                        first     <= 1'b0;
                        if (dat_last) begin
                            dat_tag_q <= dat_tag;
                            state     <= ST_TRAILER;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cug_checker.sv
module cug_checker
    import cug_pkg::*;
#(
    parameter int unsigned VER_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic [VER_W-1:0] ver_q,
    input logic             commit_we,
    input logic             done,
    input logic [2:0]       result,
    input logic             integ_fail,
    input logic             mac_start,
    input logic             mac_valid,
    input logic             mac_last,
    input logic             dat_ready
);

    AST_VER_STEP: assert property (@(posedge clk) disable iff (rst)
        (ver_q != $past(ver_q)) |-> (ver_q == $past(ver_q) + 1'b1)); // R4

    AST_VER_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (ver_q != $past(ver_q)) |-> commit_we); // R4

    AST_COMMIT_WITH_OK: assert property (@(posedge clk) disable iff (rst)
        commit_we |-> (done && result == RES_OK)); // R5

    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (rst)
        commit_we |=> !commit_we); // R5

    AST_FAIL_FLAG: assert property (@(posedge clk) disable iff (rst)
        (done && (result == RES_CMD_BAD || result == RES_DAT_BAD)) |-> integ_fail); // R6

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (&ver_q) |=> (&ver_q)); // R10

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!done) |-> ($stable(result) && $stable(integ_fail))); // R9

    AST_START_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        (mac_start || mac_last) |-> mac_valid); // R1

    AST_NO_DATA_DURING_MAC: assert property (@(posedge clk) disable iff (rst)
        mac_last |-> !dat_ready); // R2

endmodule

bind cfg_update_guard cug_checker #(
    .VER_W (VER_W)
) u_cug_checker (
    .clk        (clk),
    .rst        (rst),
    .ver_q      (ver_q),
    .commit_we  (commit_we),
    .done       (done),
    .result     (result),
    .integ_fail (integ_fail),
    .mac_start  (mac_start),
    .mac_valid  (mac_valid),
    .mac_last   (mac_last),
    .dat_ready  (dat_ready)
);

// File: tb/cfg_update_guard_test.sv
module cfg_update_guard_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [7:0]  req_cmd = '0;
    logic [15:0] req_tag = '0;
    logic        dat_valid = 1'b0;
    logic        dat_ready;
    logic [7:0]  dat_word = '0;
    logic        dat_last = 1'b0;
    logic [15:0] dat_tag = '0;
    logic        mac_start;
    logic        mac_valid;
    logic [7:0]  mac_word;
    logic        mac_last;
    logic        mac_done;
    logic [15:0] mac_result;
    logic [7:0]  ver_q;
    logic        commit_we;
    logic        done;
    logic [2:0]  result;
    logic        integ_fail;

    int nchk = 0;
    int nerr = 0;
    int ncommit = 0;
    logic [7:0] ver_m = 8'hFD;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_update_guard #(
        .CMD_W      (8),
        .DATA_W     (8),
        .TAG_W      (16),
        .VER_W      (8),
        .VER_INIT   (8'hFD),
        .OPC_W      (4),
        .UPDATE_OPC (4'hA)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_cmd    (req_cmd),
        .req_tag    (req_tag),
        .dat_valid  (dat_valid),
        .dat_ready  (dat_ready),
        .dat_word   (dat_word),
        .dat_last   (dat_last),
        .dat_tag    (dat_tag),
        .mac_start  (mac_start),
        .mac_valid  (mac_valid),
        .mac_word   (mac_word),
        .mac_last   (mac_last),
        .mac_done   (mac_done),
        .mac_result (mac_result),
        .ver_q      (ver_q),
        .commit_we  (commit_we),
        .done       (done),
        .result     (result),
        .integ_fail (integ_fail)
    );

    function automatic logic [15:0] mixw(input logic [15:0] a, input logic [7:0] w);
        return ({a[12:0], a[15:13]} ^ {w, ~w}) + 16'h3C5A;
    endfunction

    // MAC engine stub: absorbs words, answers three cycles after the last one
    logic [15:0] acc;
    logic [15:0] res_hold;
    int          lat;
    int          nlog;
    int          nstart;
    logic [7:0]  wlog [64];

    always @(posedge clk) begin
        logic [15:0] nxt;
        mac_done <= 1'b0;
        if (rst) begin
            acc <= '0; res_hold <= '0; lat <= 0; nlog <= 0; nstart <= 0;
            mac_result <= '0;
        end else begin
            if (mac_valid) begin
                nxt = mixw(mac_start ? 16'h0000 : acc, mac_word);
                acc <= nxt;
                if (nlog < 64) wlog[nlog] <= mac_word;
                nlog <= nlog + 1;
                if (mac_start) nstart <= nstart + 1;
                if (mac_last) begin
                    res_hold <= nxt;
                    lat      <= 3;
                end
            end
            if (lat > 0) begin
                lat <= lat - 1;
                if (lat == 1) begin
                    mac_done   <= 1'b1;
                    mac_result <= res_hold;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && commit_we) ncommit <= ncommit + 1;
    end

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (act !== expv) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    task automatic run_update(input logic [7:0] cmdw, input int n, input logic [15:0] cflip,
                              input logic [15:0] dflip, input logic [2:0] exp_res);
        logic [7:0]  cs [3];
        logic [7:0]  ds [12];
        logic [7:0]  cand;
        logic [7:0]  vexp;
        logic [15:0] ctag;
        logic [15:0] dtag;
        int base, cbase, sbase, spin, nexp;
        bit ok;
        ok   = (exp_res == 3'd1);
        cand = ver_m + 8'd1;
        cs[0] = cmdw; cs[1] = 8'h00; cs[2] = cand;
        for (int i = 0; i < n; i++) ds[i] = cmdw ^ 8'(i * 37 + 5);
        ds[n] = 8'h01; ds[n+1] = cand;
        ctag = '0;
        for (int i = 0; i < 3; i++) ctag = mixw(ctag, cs[i]);
        dtag = '0;
        for (int i = 0; i < n + 2; i++) dtag = mixw(dtag, ds[i]);
        ctag = ctag ^ cflip;
        dtag = dtag ^ dflip;
        base = nlog; cbase = ncommit; sbase = nstart;

        @(negedge clk);
        req_valid = 1'b1; req_cmd = cmdw; req_tag = ctag; dat_tag = dtag;
        @(negedge clk);
        req_valid = 1'b0;
        if (cflip == '0) begin
            for (int i = 0; i < n; i++) begin
                dat_valid = 1'b1; dat_word = ds[i]; dat_last = (i == n - 1);
                spin = 0;
                while (!dat_ready && spin < 200) begin @(negedge clk); spin++; end
                @(negedge clk);
            end
            dat_valid = 1'b0; dat_last = 1'b0;
        end
        spin = 0;
        while (!done && spin < 200) begin @(negedge clk); spin++; end

        chk("R9", "done pulse seen", 32'(done), 32'd1);
        chk(ok ? "R4" : (exp_res == 3'd2 ? "R3" : "R6"), "result code", 32'(result), 32'(exp_res));
        chk("R5", "commit_we with done", 32'(commit_we), 32'(ok));
        chk(exp_res == 3'd2 ? "R3" : "R6", "integ_fail", 32'(integ_fail), 32'(!ok));
        vexp = ok ? cand : ver_m;
        chk("R4", "version after outcome", 32'(ver_q), 32'(vexp));
        ver_m = vexp;

        nexp = (cflip != '0) ? 3 : 3 + n + 2;
        chk(cflip != '0 ? "R3" : "R2", "MAC word count", 32'(nlog - base), 32'(nexp));
        for (int k = 0; k < 3; k++)
            chk("R1", $sformatf("command MAC word %0d", k), 32'(wlog[base + k]), 32'(cs[k]));
        if (cflip == '0)
            for (int k = 0; k < n + 2; k++)
                chk("R2", $sformatf("data MAC word %0d", k), 32'(wlog[base + 3 + k]), 32'(ds[k]));
        chk(cflip != '0 ? "R1" : "R2", "MAC start count", 32'(nstart - sbase), (cflip != '0) ? 32'd1 : 32'd2);

        @(negedge clk);
        chk("R9", "done low after pulse", 32'(done), 32'd0);
        chk("R5", "commit pulses", 32'(ncommit - cbase), 32'(ok));
    endtask

    task automatic test_reset();
        chk("R11", "done", 32'(done), 32'd0);
        chk("R11", "commit_we", 32'(commit_we), 32'd0);
        chk("R11", "integ_fail", 32'(integ_fail), 32'd0);
        chk("R11", "dat_ready", 32'(dat_ready), 32'd0);
        chk("R11", "mac_valid", 32'(mac_valid), 32'd0);
        chk("R11", "mac_start", 32'(mac_start), 32'd0);
        chk("R11", "result", 32'(result), 32'd0);
        chk("R11", "version", 32'(ver_q), 32'hFD);
    endtask

    task automatic test_ignored();
        int base; bit seen; logic [2:0] r0; logic [7:0] v0; logic f0;
        base = nlog; r0 = result; v0 = ver_q; f0 = integ_fail; seen = 0;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = 8'h53; req_tag = 16'h1234;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (done || dat_ready) seen = 1;
            @(negedge clk);
        end
        chk("R8", "no MAC words", 32'(nlog - base), 32'd0);
        chk("R8", "no done or data phase", 32'(seen), 32'd0);
        chk("R8", "result unchanged", 32'(result), 32'(r0));
        chk("R8", "integ_fail unchanged", 32'(integ_fail), 32'(f0));
        chk("R8", "version unchanged", 32'(ver_q), 32'(v0));
    endtask

    task automatic test_hold();
        logic [2:0] r0; logic f0;
        r0 = result; f0 = integ_fail;
        repeat (12) @(negedge clk);
        chk("R9", "result held", 32'(result), 32'(r0));
        chk("R9", "integ_fail held", 32'(integ_fail), 32'(f0));
    endtask

    task automatic test_exhausted();
        int base, cbase, spin;
        base = nlog; cbase = ncommit;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = 8'hA7; req_tag = 16'h0;
        @(negedge clk);
        req_valid = 1'b0;
        spin = 0;
        while (!done && spin < 50) begin @(negedge clk); spin++; end
        chk("R10", "done seen", 32'(done), 32'd1);
        chk("R10", "result code", 32'(result), 32'd4);
        chk("R10", "integ_fail low", 32'(integ_fail), 32'd0);
        repeat (5) @(negedge clk);
        chk("R10", "no MAC words", 32'(nlog - base), 32'd0);
        chk("R10", "version kept", 32'(ver_q), 32'hFF);
        chk("R10", "no commit", 32'(ncommit - cbase), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: run did not complete in time");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        run_update(8'hA3, 3, 16'h0000, 16'h0000, 3'd1);   // success, FD -> FE
        run_update(8'hA4, 2, 16'h8000, 16'h0000, 3'd2);   // R7: command tag differs in top bit only
        run_update(8'hA5, 2, 16'h0000, 16'h0001, 3'd3);   // R7: data tag differs in bottom bit only
        test_hold();
        test_ignored();
        run_update(8'hAC, 1, 16'h0000, 16'h0000, 3'd1);   // single-word stream, FE -> FF
        test_exhausted();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule